// File: doc/BRIEF.md
# Ultra DMA Data-In Strobe Timing Generator

This block drives the device-side data strobe during an Ultra DMA data-in burst. A 2-bit timing factor written by firmware sets the spacing between strobe edges. That spacing is two plus the factor, counted in UDMA clock periods, so a larger factor gives a slower transfer mode. Firmware raises the factor after repeated CRC errors on data-in bursts. With a system clock near 33.87 MHz, factor 0 gives about 59 ns per edge, factor 1 about 88.6 ns and factor 2 about 118 ns.

The UDMA timing comes from one of two sources, chosen by a select input. When the select is low, every system clock cycle counts. When it is high, only cycles in which the auxiliary clock-enable input is high count. Every strobe edge, rising or falling, launches one 16-bit data word. A one-cycle launch pulse marks each edge. While no word is available the strobe holds its level, and the edge count restarts once data is available again. A stop request lets the current interval run out and then parks the strobe high.

Top module: `udma_strobe_gen`

## Requirements
- R1: While reset is low, and afterwards until a burst starts, `dstrobe` is 1 and `word_launch` is 0.
- R2: With `clk_sel` = 0 and a word always available, strobe edges are exactly 2 + `timing_factor` clock cycles apart, for each factor value 0 to 3 (value 3 gives 5 cycles).
- R3: `word_launch` is high for exactly one cycle in each cycle where `dstrobe` has changed level, and is low in all other cycles.
- R4: The first edge of a burst is falling. It appears 2 + factor UDMA ticks after the cycle in which `burst_start` is sampled, using the factor sampled in that same cycle.
- R5: With `clk_sel` = 1, only cycles with `aux_tick` = 1 count as UDMA ticks. An edge therefore needs 2 + factor such ticks, and no edge occurs in a cycle where `aux_tick` was 0.
- R6: In any cycle where `word_avail` is sampled 0, the strobe does not change and the tick count returns to zero. The next edge comes 2 + factor ticks after `word_avail` is sampled 1 again.
- R7: A new `timing_factor` value is taken only in the cycle of a strobe edge (or at burst start). It governs the following interval and never shortens or stretches the interval in progress.
- R8: After `burst_stop`, the interval in progress completes. If `dstrobe` is low it then rises with a final launch pulse. If it is already high there is no edge. The block then returns to idle with `dstrobe` = 1.
- R9: `burst_start` during a burst and `burst_stop` while idle have no effect on `dstrobe` or `word_launch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 1 | 1: time from `aux_tick`; 0: time from every system clock |
| aux_tick | input | 1 | Auxiliary UDMA clock, as a clock enable in the system clock domain |
| timing_factor | input | 2 | Timing factor; edge spacing is 2 + factor UDMA ticks |
| burst_start | input | 1 | Start a data-in burst (used only when idle) |
| burst_stop | input | 1 | End the burst after the interval in progress |
| word_avail | input | 1 | A data word is ready to be launched |
| dstrobe | output | 1 | Device data strobe |
| word_launch | output | 1 | One-cycle pulse on every strobe edge |

## Verification
The bench sweeps every factor value under both clock sources and predicts each edge by counting UDMA ticks. A wrong affine offset, such as spacing of factor + 1, would shift every edge and show up at once. An auxiliary source that is not gated would produce edges too early. Random gaps in `word_avail` catch a counter that resumes instead of restarting; that design would fire early after each gap. Factor changes in random cycles catch a design that reloads in mid-interval, which would give intervals of a length between the old and new values. Stop requests at every offset within a burst check both parking cases: a design that misses the final rising edge would be left parked low, and one that toggles a high strobe would produce a spurious launch.

// File: rtl/udma_strobe_pkg.sv
// Package: shared types for the Ultra DMA strobe timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package udma_strobe_pkg;

    // Burst sequencing states
    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_RUN   = 2'd1,
        BST_DRAIN = 2'd2
    } bst_e;

    // Counter width needed to hold (2**fw) as the last count value
    function automatic int cnt_width(input int fw);
        return fw + 1;
    endfunction

endpackage

// File: rtl/udma_tick_sel.sv
// Module: picks the UDMA tick source.
// Does: with clk_sel low, every system cycle is a tick; with clk_sel high,
//       the auxiliary enable decides. A parameter can tie the block to the
//       system clock only.
// Assumes: aux_tick is already synchronous to clk, at most one pulse per cycle.
module udma_tick_sel #(
    parameter bit AUX_PRESENT = 1'b1
) (
    input  logic clk_sel,
    input  logic aux_tick,
    output logic tick
);

    generate
        if (AUX_PRESENT) begin : g_mux
            // Choose between the free-running and the gated tick
            always_comb tick = clk_sel ? aux_tick : 1'b1;
        end else begin : g_sys
            logic unused_in;
            // Auxiliary path absent: every cycle counts
            always_comb begin
                unused_in = clk_sel ^ aux_tick;
                tick      = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/udma_edge_timer.sv
// Module: counts UDMA ticks between strobe edges.
// Does: keeps a tick count and a latched limit (factor + 1). It raises
//       'expire' in the cycle whose tick completes 2 + factor ticks. The
//       factor is latched only at load or at expiry. A cycle without a
//       word available clears the count.
// Assumes: load and run are never both high.
module udma_edge_timer #(
    parameter int FACTOR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                run,
    input  logic                avail,
    input  logic                tick,
    input  logic [FACTOR_W-1:0] factor,
    output logic                expire
);

    localparam int CNT_W = udma_strobe_pkg::cnt_width(FACTOR_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] next_lim;

    // Next limit from the live factor
    always_comb next_lim = CNT_W'(factor) + CNT_W'(1);

    // Interval ends on the tick that meets the limit
    always_comb expire = run && avail && tick && (cnt == lim);

    // Tick counter and limit latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= CNT_W'(1);
        end else if (load) begin
            cnt <= '0;
            lim <= next_lim;
        end else if (run) begin
            if (!avail) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == lim) begin
                    cnt <= '0;
                    lim <= next_lim;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end else begin
            cnt <= '0;
        end
    end

    AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim);                                                    // R2
    AST_LIMIT_HELD_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(expire)) |-> $stable(lim));             // R7
    AST_NO_COUNT_WITHOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(avail)) |-> (cnt == '0));                 // R6

endmodule

// File: rtl/udma_strobe_ctl.sv
// Module: burst sequencing and strobe register.
// Does: starts a burst from idle, toggles the strobe and pulses the launch
//       output on each timer expiry. On a stop request it drains: at the
//       next expiry it raises a low strobe (final edge) or leaves a high
//       one alone, then returns to idle.
// Assumes: expire is only high while the burst is active.
module udma_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic expire,
    output logic load,
    output logic run,
    output logic strobe,
    output logic launch
);

    import udma_strobe_pkg::*;

    bst_e state;

    // Decode of state for the timer
    always_comb begin
        load = (state == BST_IDLE) && start;
        run  = (state != BST_IDLE);
    end

    // State, strobe level and launch pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BST_IDLE;
            strobe <= 1'b1;
            launch <= 1'b0;
        end else begin
            launch <= 1'b0;
            case (state)
                BST_IDLE: begin
                    if (start) state <= BST_RUN;
                end
                BST_RUN: begin
                    if (stop) state <= BST_DRAIN;
                    if (expire) begin
                        strobe <= ~strobe;
                        launch <= 1'b1;
                    end
                end
                BST_DRAIN: begin
                    if (expire) begin
                        state <= BST_IDLE;
                        if (!strobe) begin
                            strobe <= 1'b1;
                            launch <= 1'b1;
                        end
                    end
                end
                default: state <= BST_IDLE;
            endcase
        end
    end

    AST_IDLE_PARKED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BST_IDLE) |-> strobe);                                // R8
    AST_LAUNCH_IFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        launch == (strobe != $past(strobe)));                           // R3
    AST_LAUNCH_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(expire));                                      // R3

endmodule

// File: rtl/udma_strobe_gen.sv
// Module: top of the Ultra DMA data-in strobe timing generator.
// Does: combines tick selection, the edge timer and the burst/strobe
//       control. Edge spacing is (2 + timing_factor) UDMA ticks.
// Assumes: all inputs are synchronous to clk; aux_tick is an enable pulse.
module udma_strobe_gen #(
    parameter int FACTOR_W    = 2,
    parameter bit AUX_PRESENT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_sel,
    input  logic                aux_tick,
    input  logic [FACTOR_W-1:0] timing_factor,
    input  logic                burst_start,
    input  logic                burst_stop,
    input  logic                word_avail,
    output logic                dstrobe,
    output logic                word_launch
);

    logic tick;
    logic expire;
    logic load;
    logic run;

    udma_tick_sel #(.AUX_PRESENT(AUX_PRESENT)) u_tick (
        .clk_sel  (clk_sel),
        .aux_tick (aux_tick),
        .tick     (tick)
    );

    udma_edge_timer #(.FACTOR_W(FACTOR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .run    (run),
        .avail  (word_avail),
        .tick   (tick),
        .factor (timing_factor),
        .expire (expire)
    );

    udma_strobe_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (burst_start),
        .stop   (burst_stop),
        .expire (expire),
        .load   (load),
        .run    (run),
        .strobe (dstrobe),
        .launch (word_launch)
    );

    AST_AUX_GATES_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_sel) && !$past(aux_tick)) |-> !word_launch);         // R5
    AST_HOLD_WITHOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_avail) |-> $stable(dstrobe));                       // R6
    AST_LAUNCH_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(word_launch) |-> !word_launch);                           // R3

endmodule

// File: tb/sim_udma_strobe_gen.sv
module sim_udma_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b0;
    logic       aux_tick = 1'b0;
    logic [1:0] timing_factor = 2'd0;
    logic       burst_start = 1'b0;
    logic       burst_stop = 1'b0;
    logic       word_avail = 1'b0;
    logic       dstrobe;
    logic       word_launch;

    int checks = 0;
    int errors = 0;

    // Bench-side expectation state
    bit       m_active = 1'b0;
    bit       m_stopping = 1'b0;
    bit       m_level = 1'b1;
    bit       m_first = 1'b0;
    int       m_ticks = 0;
    int       m_period = 2;
    int       n_launch = 0;
    int       n_changes = 0;
    logic     last_strobe = 1'b1;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;   // 125 MHz

    udma_strobe_gen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_sel       (clk_sel),
        .aux_tick      (aux_tick),
        .timing_factor (timing_factor),
        .burst_start   (burst_start),
        .burst_stop    (burst_stop),
        .word_avail    (word_avail),
        .dstrobe       (dstrobe),
        .word_launch   (word_launch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic adv_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // One cycle: drive at negedge, let the posedge sample, check at next negedge
    task automatic step(input bit av, input bit tk, input logic [1:0] f,
                        input bit sel, input bit st, input bit sp, input string req);
        bit t;
        bit exp_launch;
        word_avail    = av;
        aux_tick      = tk;
        timing_factor = f;
        clk_sel       = sel;
        burst_start   = st;
        burst_stop    = sp;
        @(negedge clk);
        t = sel ? tk : 1'b1;
        exp_launch = 1'b0;
        if (!m_active) begin
            if (st) begin
                m_active   = 1'b1;
                m_stopping = 1'b0;
                m_first    = 1'b1;
                m_ticks    = 0;
                m_period   = 2 + int'(f);
            end
        end else begin
            if (!av) begin
                m_ticks = 0;
            end else if (t) begin
                m_ticks++;
                if (m_ticks == m_period) begin
                    m_ticks  = 0;
                    m_period = 2 + int'(f);
                    if (m_stopping) begin
                        m_active = 1'b0;
                        if (!m_level) begin
                            m_level    = 1'b1;
                            exp_launch = 1'b1;
                        end
                    end else begin
                        m_level    = ~m_level;
                        exp_launch = 1'b1;
                        if (m_first) begin
                            m_first = 1'b0;
                            // R4: first edge of a burst is falling
                            chk(dstrobe == 1'b0, "R4", dstrobe, 0);
                        end
                    end
                end
            end
            if (sp && m_active) m_stopping = 1'b1;
        end
        chk(word_launch == exp_launch, req, word_launch, exp_launch);
        chk(dstrobe == m_level, req, dstrobe, m_level);
        if (word_launch) n_launch++;
        if (dstrobe != last_strobe) n_changes++;
        last_strobe = dstrobe;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(dstrobe == 1'b1, "R1", dstrobe, 1);
        chk(word_launch == 1'b0, "R1", word_launch, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            adv_lfsr();
            step(lfsr[0], lfsr[1], lfsr[3:2], lfsr[4], 1'b0, 1'b0, "R1");
        end
        // R9: stop while idle does nothing
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, "R9");

        // R2 / R5: every factor under both clock sources
        for (int sel = 0; sel < 2; sel++) begin
            for (int f = 0; f < 4; f++) begin
                step(1'b1, 1'b1, 2'(f), sel[0], 1'b1, 1'b0, sel ? "R5" : "R2");
                for (int i = 0; i < 40; i++) begin
                    adv_lfsr();
                    step(1'b1, lfsr[0] | lfsr[5], 2'(f), sel[0], 1'b0, 1'b0,
                         sel ? "R5" : "R2");
                end
                step(1'b1, 1'b1, 2'(f), sel[0], 1'b0, 1'b1, "R8");
                for (int i = 0; i < 30; i++) begin
                    adv_lfsr();
                    step(1'b1, lfsr[0] | lfsr[5], 2'(f), sel[0], 1'b0, 1'b0, "R8");
                end
            end
        end
        // R3: every strobe change carried a launch pulse
        chk(n_launch == n_changes, "R3", n_launch, n_changes);
        chk(n_launch > 50, "R3", n_launch, 51);

        // R8: stop at every offset, both strobe levels
        for (int k = 0; k < 12; k++) begin
            step(1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, "R8");
            for (int i = 0; i < k; i++) step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, "R8");
            step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, "R8");
            for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, "R8");
            chk(dstrobe == 1'b1 && !m_active, "R8", dstrobe, 1);
        end

        // R6: word gaps under both sources
        for (int f = 0; f < 4; f++) begin
            step(1'b1, 1'b1, 2'(f), f[0], 1'b1, 1'b0, "R6");
            for (int i = 0; i < 70; i++) begin
                adv_lfsr();
                step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[7], 2'(f), f[0], 1'b0, 1'b0, "R6");
            end
            step(1'b1, 1'b1, 2'(f), f[0], 1'b0, 1'b1, "R6");
            for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 2'(f), f[0], 1'b0, 1'b0, "R6");
        end

        // R7: factor changes in random cycles
        begin
            logic [1:0] fac = 2'd3;
            step(1'b1, 1'b1, fac, 1'b0, 1'b1, 1'b0, "R7");
            for (int i = 0; i < 200; i++) begin
                adv_lfsr();
                if (lfsr[1:0] == 2'b00) fac = lfsr[5:4];
                step(1'b1, 1'b1, fac, 1'b0, 1'b0, 1'b0, "R7");
            end
            step(1'b1, 1'b1, fac, 1'b0, 1'b0, 1'b1, "R7");
            for (int i = 0; i < 10; i++) step(1'b1, 1'b1, fac, 1'b0, 1'b0, 1'b0, "R7");
        end

        // R9: start pulses during a burst are ignored
        step(1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, "R9");
        for (int i = 0; i < 60; i++) begin
            adv_lfsr();
            step(1'b1, 1'b1, 2'd2, 1'b0, lfsr[0], 1'b0, "R9");
        end
        step(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, "R9");
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, "R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule